// File: doc/BRIEF.md
# Tape Read Pattern Run-Length Detector

This block sits behind the read-side pattern qualifiers of a tape controller. It watches three pattern flags: continuous noise, the all-ones block pattern and the tape-mark pattern. Each flag is sampled only on a sampling strobe that runs at twice the bit-cell rate, so every run length is counted in half-cell units. When a flag has been present on an unbroken series of strobes long enough, the block raises a sticky status bit for that pattern.

The run length needed depends on the recording density (high density or phase-encoded density) and on whether the channel is in write or read status. Each pattern has its own four-entry threshold table, indexed by those two selectors. A read-enable input clears everything and holds it clear. With neither density selected, which is the low-density NRZ case, the block never raises a status bit.

Top module: `tpd_detector`

## Requirements
- R1: During and right after reset, all three status outputs are 0.
- R2: With table index 0 = high-density write, 1 = high-density read, 2 = phase-density write and 3 = phase-density read, `noiseBlock` rises after 92, 44, 46 and 22 consecutive present strobes respectively.
- R3: Using the same index, `blockSeen` rises after 50, 50, 25 and 25 consecutive present strobes, which is 25 and 12.5 bit cells.
- R4: Using the same index, `markSeen` rises after 608, 84, 168 and 42 consecutive present strobes.
- R5: A status bit is 1 right after the clock edge that samples the N-th consecutive present strobe, where N is the threshold. A strobe on which the pattern is absent restarts that pattern's run at zero.
- R6: Once set, a status bit stays 1 while `readOk` is 1, whatever the pattern inputs do.
- R7: A clock edge with `readOk` = 0 clears all status bits and all runs. They stay clear for as long as `readOk` is 0.
- R8: With `densHigh` = `densLow` = 0, no status bit is ever set. With both at 1, the high-density thresholds apply.
- R9: Clock cycles with `cellStrobe` = 0 neither extend nor break a run, even if a pattern is present during them.
- R10: A run counter saturates at its all-ones value, so a very long run never wraps around and never drops a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cellStrobe | input | 1 | Sampling strobe at twice the bit-cell rate |
| noisePat | input | 1 | Qualified noise pattern present |
| blockPat | input | 1 | Qualified all-ones block pattern present |
| markPat | input | 1 | Qualified tape-mark pattern present |
| densHigh | input | 1 | High-density mode select (takes precedence) |
| densLow | input | 1 | Phase-encoded density mode select |
| writeMode | input | 1 | 1 = write status, 0 = read status |
| readOk | input | 1 | Enable; 0 clears and holds all state |
| noiseBlock | output | 1 | Sticky noise-block status |
| blockSeen | output | 1 | Sticky block-detected status |
| markSeen | output | 1 | Sticky tape-mark-detected status |

## Verification
Every result is registered once. A status bit or a clear is therefore due just after the same rising edge that samples the causing strobe or the low `readOk`, with no added latency. The bench applies inputs, waits for one edge, updates its own model from the inputs it applied, and compares 1 ns later, well clear of the next edge. Directed runs stop exactly one strobe short of each threshold and then one strobe on it, so any off-by-one shows at the ports.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic       sample;   // sampling strobe this cycle
    logic       clear;    // hold all runs and status at zero
    logic       enable;   // a detecting density is selected
    logic [1:0] sel;      // {phaseDensity, readStatus} table index
  } tpdCtrl_t;

  localparam int unsigned NumPat = 3;
  localparam int unsigned NumSel = 4;

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned bitsFor(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/tpd_ctrl.sv
module tpd_ctrl
  import tpd_pkg::*;
(
  input  logic     cellStrobe,
  input  logic     densHigh,
  input  logic     densLow,
  input  logic     writeMode,
  input  logic     readOk,
  output tpdCtrl_t ctrlOut
);

  logic phaseSel;
  logic readSel;

  always_comb begin
    // high density wins when both selects are set
    phaseSel       = !densHigh;
    readSel        = !writeMode;
    ctrlOut.sample = cellStrobe;
    ctrlOut.clear  = !readOk;
    ctrlOut.enable = densHigh || densLow;
    ctrlOut.sel    = {phaseSel, readSel};
  end

endmodule

// File: rtl/tpd_run_tracker.sv
module tpd_run_tracker
  import tpd_pkg::*;
#(
  parameter int unsigned CntW = 10,
  parameter logic [NumSel-1:0][CntW-1:0] Thr = '0
) (
  input  logic     clk,
  input  logic     rstN,
  input  tpdCtrl_t ctrl,
  input  logic     present,
  output logic     status
);

  localparam logic [CntW-1:0] RunMax = '1;

  logic [CntW-1:0] runQ;
  logic [CntW:0]   runInc;
  logic [CntW-1:0] thrSel;
  logic            reach;
  logic            statusQ;

  always_comb begin
    runInc = {1'b0, runQ} + 1'b1;
    thrSel = Thr[ctrl.sel];
    reach  = runInc >= {1'b0, thrSel};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= '0;
      statusQ <= 1'b0;
    end else if (ctrl.clear) begin
      runQ    <= '0;
      statusQ <= 1'b0;
    end else if (ctrl.sample) begin
      if (present && ctrl.enable) begin
        if (runQ != RunMax) runQ <= runQ + 1'b1;
        if (reach) statusQ <= 1'b1;
      end else begin
        runQ <= '0;
      end
    end
  end

  assign status = statusQ;

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clear |=> (!statusQ && runQ == '0));

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && !ctrl.clear) |=> statusQ);

  // R8
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ) |-> $past(ctrl.sample && ctrl.enable && present && !ctrl.clear));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.clear && !ctrl.sample) |=> ($stable(runQ) && $stable(statusQ)));

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ == RunMax && !ctrl.clear && ctrl.sample && present && ctrl.enable)
      |=> runQ == RunMax);

endmodule

// File: rtl/tpd_datapath.sv
module tpd_datapath
  import tpd_pkg::*;
#(
  parameter int unsigned CntW = 10,
  parameter logic [NumPat-1:0][NumSel-1:0][CntW-1:0] ThrTable = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  tpdCtrl_t          ctrl,
  input  logic [NumPat-1:0] patIn,
  output logic [NumPat-1:0] statusOut
);

  for (genvar g = 0; g < NumPat; g++) begin : gTrack
    tpd_run_tracker #(
      .CntW(CntW),
      .Thr (ThrTable[g])
    ) track_i (
      .clk    (clk),
      .rstN   (rstN),
      .ctrl   (ctrl),
      .present(patIn[g]),
      .status (statusOut[g])
    );
  end

endmodule

// File: rtl/tpd_detector.sv
module tpd_detector
  import tpd_pkg::*;
#(
  // thresholds in half-cell strobes
  parameter int unsigned NoiseW6250 = 92,
  parameter int unsigned NoiseR6250 = 44,
  parameter int unsigned NoiseW1600 = 46,
  parameter int unsigned NoiseR1600 = 22,
  parameter int unsigned BlockW6250 = 50,
  parameter int unsigned BlockR6250 = 50,
  parameter int unsigned BlockW1600 = 25,
  parameter int unsigned BlockR1600 = 25,
  parameter int unsigned MarkW6250  = 608,
  parameter int unsigned MarkR6250  = 84,
  parameter int unsigned MarkW1600  = 168,
  parameter int unsigned MarkR1600  = 42
) (
  input  logic clk,
  input  logic rstN,
  input  logic cellStrobe,
  input  logic noisePat,
  input  logic blockPat,
  input  logic markPat,
  input  logic densHigh,
  input  logic densLow,
  input  logic writeMode,
  input  logic readOk,
  output logic noiseBlock,
  output logic blockSeen,
  output logic markSeen
);

  localparam int unsigned MaxNoise = maxOf(maxOf(NoiseW6250, NoiseR6250), maxOf(NoiseW1600, NoiseR1600));
  localparam int unsigned MaxBlock = maxOf(maxOf(BlockW6250, BlockR6250), maxOf(BlockW1600, BlockR1600));
  localparam int unsigned MaxMark  = maxOf(maxOf(MarkW6250, MarkR6250), maxOf(MarkW1600, MarkR1600));
  localparam int unsigned MaxThr   = maxOf(maxOf(MaxNoise, MaxBlock), MaxMark);
  localparam int unsigned CntW     = bitsFor(MaxThr);

  localparam logic [NumSel-1:0][CntW-1:0] NoiseThr =
    {CntW'(NoiseR1600), CntW'(NoiseW1600), CntW'(NoiseR6250), CntW'(NoiseW6250)};
  localparam logic [NumSel-1:0][CntW-1:0] BlockThr =
    {CntW'(BlockR1600), CntW'(BlockW1600), CntW'(BlockR6250), CntW'(BlockW6250)};
  localparam logic [NumSel-1:0][CntW-1:0] MarkThr =
    {CntW'(MarkR1600), CntW'(MarkW1600), CntW'(MarkR6250), CntW'(MarkW6250)};
  localparam logic [NumPat-1:0][NumSel-1:0][CntW-1:0] ThrTable = {MarkThr, BlockThr, NoiseThr};

  tpdCtrl_t          ctrl;
  logic [NumPat-1:0] statusVec;

  tpd_ctrl ctrl_i (
    .cellStrobe(cellStrobe),
    .densHigh  (densHigh),
    .densLow   (densLow),
    .writeMode (writeMode),
    .readOk    (readOk),
    .ctrlOut   (ctrl)
  );

  tpd_datapath #(
    .CntW    (CntW),
    .ThrTable(ThrTable)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .patIn    ({markPat, blockPat, noisePat}),
    .statusOut(statusVec)
  );

  assign noiseBlock = statusVec[0];
  assign blockSeen  = statusVec[1];
  assign markSeen   = statusVec[2];

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!noiseBlock && !blockSeen && !markSeen));

  // R8
  low_density_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!densHigh && !densLow && !$past(densHigh) && !$past(densLow)
      && !$past(noiseBlock) && !$past(blockSeen) && !$past(markSeen))
      |-> (!noiseBlock && !blockSeen && !markSeen));

endmodule

// File: tb/tpd_detector_tb_top.sv
`timescale 1ns/1ps
module tpd_detector_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cellStrobe = 1'b0;
  logic noisePat = 1'b0, blockPat = 1'b0, markPat = 1'b0;
  logic densHigh = 1'b1, densLow = 1'b0, writeMode = 1'b0, readOk = 1'b0;
  logic noiseBlock, blockSeen, markSeen;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int unsigned noiseT[4] = '{92, 44, 46, 22};
  int unsigned blockT[4] = '{50, 50, 25, 25};
  int unsigned markT[4]  = '{608, 84, 168, 42};
  localparam int unsigned RunSat = 1023;

  int unsigned mRun[3];
  bit mStat[3];

  always #2.5 clk = ~clk;

  tpd_detector dut_i (
    .clk(clk), .rstN(rstN), .cellStrobe(cellStrobe),
    .noisePat(noisePat), .blockPat(blockPat), .markPat(markPat),
    .densHigh(densHigh), .densLow(densLow), .writeMode(writeMode), .readOk(readOk),
    .noiseBlock(noiseBlock), .blockSeen(blockSeen), .markSeen(markSeen)
  );

  function automatic string tagOf(input int p);
    return (p == 0) ? "R2" : (p == 1) ? "R3" : "R4";
  endfunction

  function automatic int unsigned thrOf(input int p);
    int idx;
    idx = (densHigh ? 0 : 2) + (writeMode ? 0 : 1);
    case (p)
      0: return noiseT[idx];
      1: return blockT[idx];
      default: return markT[idx];
    endcase
  endfunction

  function automatic logic outOf(input int p);
    return (p == 0) ? noiseBlock : (p == 1) ? blockSeen : markSeen;
  endfunction

  function automatic logic patOf(input int p);
    return (p == 0) ? noisePat : (p == 1) ? blockPat : markPat;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    for (int p = 0; p < 3; p++) begin
      if (!readOk) begin
        mRun[p] = 0;
        mStat[p] = 1'b0;
      end else if (cellStrobe) begin
        if (patOf(p) && (densHigh || densLow)) begin
          if (mRun[p] + 1 >= thrOf(p)) mStat[p] = 1'b1;
          if (mRun[p] < RunSat) mRun[p]++;
        end else begin
          mRun[p] = 0;
        end
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    #1;
    for (int p = 0; p < 3; p++) check(tagOf(p), "model compare", outOf(p), mStat[p]);
  endtask

  task automatic drive(input int n, input bit s, input bit [2:0] pats);
    cellStrobe = s;
    {markPat, blockPat, noisePat} = pats;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic setMode(input int m);
    densHigh  = (m < 2);
    densLow   = (m >= 2);
    writeMode = ((m % 2) == 0);
  endtask

  task automatic clearAll();
    readOk = 1'b0;
    drive(1, 1'b0, 3'b000);
    readOk = 1'b1;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned thr;
    bit [2:0] st;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "noise in reset", noiseBlock, 1'b0);
    check("R1", "block in reset", blockSeen, 1'b0);
    check("R1", "mark in reset", markSeen, 1'b0);
    rstN = 1'b1;
    readOk = 1'b1;
    tick();
    check("R1", "after reset", noiseBlock | blockSeen | markSeen, 1'b0);

    // exact thresholds per mode and pattern (R2 R3 R4 R5)
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 3; p++) begin
        setMode(m);
        clearAll();
        thr = thrOf(p);
        drive(thr - 1, 1'b1, 3'b001 << p);
        check(tagOf(p), "one strobe short", outOf(p), 1'b0);
        drive(1, 1'b1, 3'b001 << p);
        check(tagOf(p), "on threshold", outOf(p), 1'b1);
        // R6: sticky while readOk high
        drive(30, 1'b1, 3'b000);
        check("R6", "sticky after pattern gone", outOf(p), 1'b1);
      end
    end

    // R5: absent strobe restarts the run (high density read noise = 44)
    setMode(1);
    clearAll();
    drive(43, 1'b1, 3'b001);
    drive(1, 1'b1, 3'b000);
    drive(43, 1'b1, 3'b001);
    check("R5", "gap restarts run", noiseBlock, 1'b0);
    drive(1, 1'b1, 3'b001);
    check("R5", "full run after gap", noiseBlock, 1'b1);

    // R9: non-strobe cycles neither count nor break
    clearAll();
    for (int i = 0; i < 43; i++) begin
      drive(1, 1'b1, 3'b001);
      drive(2, 1'b0, 3'b001);
    end
    check("R9", "idle cycles not counted", noiseBlock, 1'b0);
    drive(10, 1'b0, 3'b000);
    check("R9", "idle absence not a break", noiseBlock, 1'b0);
    drive(1, 1'b1, 3'b001);
    check("R9", "run continues across idles", noiseBlock, 1'b1);

    // R7: readOk low clears and holds clear
    drive(50, 1'b1, 3'b111);
    readOk = 1'b0;
    drive(1, 1'b1, 3'b111);
    check("R7", "clear noise", noiseBlock, 1'b0);
    check("R7", "clear block", blockSeen, 1'b0);
    drive(100, 1'b1, 3'b111);
    check("R7", "held clear", noiseBlock | blockSeen | markSeen, 1'b0);
    readOk = 1'b1;
    drive(43, 1'b1, 3'b001);
    check("R7", "run restarted from zero", noiseBlock, 1'b0);

    // R8: low density never sets
    densHigh = 1'b0; densLow = 1'b0; writeMode = 1'b0;
    clearAll();
    drive(700, 1'b1, 3'b111);
    check("R8", "no noise in low density", noiseBlock, 1'b0);
    check("R8", "no block in low density", blockSeen, 1'b0);
    check("R8", "no mark in low density", markSeen, 1'b0);
    // R8: both selects -> high density read (44, not 22)
    densHigh = 1'b1; densLow = 1'b1;
    clearAll();
    drive(43, 1'b1, 3'b001);
    check("R8", "both selects, 43 strobes", noiseBlock, 1'b0);
    drive(1, 1'b1, 3'b001);
    check("R8", "both selects, 44 strobes", noiseBlock, 1'b1);

    // R10: long run past counter range stays set
    setMode(3);
    clearAll();
    drive(1100, 1'b1, 3'b100);
    check("R10", "long run keeps status", markSeen, 1'b1);

    // random phase
    st = 3'b000;
    for (int i = 0; i < 6000; i++) begin
      for (int p = 0; p < 3; p++) if (($urandom % 150) == 0) st[p] = ~st[p];
      if (($urandom % 400) == 0) setMode($urandom % 4);
      if (($urandom % 1200) == 0) begin densHigh = 1'b0; densLow = 1'b0; end
      readOk = (($urandom % 600) != 0);
      drive(1, (($urandom % 3) != 0), st);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule